// File: doc/BRIEF.md
# Receiver Address-Mark Mute Filter

This block sits between a serial receiver's character deserializer and the receive holding register. Each completed character word goes through it. The block decides whether the character is kept, and it tracks a mute state driven by address marks. A character counts as an address when the most significant bit of its data field is set. Its low four bits then name the target node, and they are compared with the programmed node address. An address that does not match mutes the receiver. An address that matches unmutes it and is itself delivered. While the receiver is muted, data characters are dropped.

The frame format comes from a length select and a parity enable. It sets which bit of the incoming word is the data MSB, so a parity bit is never taken for the address mark. The block also drives that bit position out to the parity checker. Software reads the stored character through a read strobe. Software may set or clear the mute state only while the holding register is empty.

Top module: `rx_mute_filter`

## Requirements
- R1: After reset, `buf_full`, `rx_req`, `overrun`, `mute_state` and `rd_data` are all 0.
- R2: One cycle after the format inputs are applied, `msb_idx` reads 8 for (`len_nine`,`par_en`)=(1,0), 7 for (1,1), 7 for (0,0) and 6 for (0,1).
- R3: A character is an address when bit `msb_idx` of `char_word` is 1; a parity bit above that position has no effect on the classification.
- R4: An address character whose bits [3:0] differ from `node_addr` sets `mute_state` to 1, whatever its previous value. Nothing is stored for it and `rx_req` stays low.
- R5: An address character whose bits [3:0] equal `node_addr` clears `mute_state`, is stored, and sets `buf_full`.
- R6: A data character is stored when `mute_state` is 0 and discarded, with no flag change, when `mute_state` is 1.
- R7: A `mute_wr` strobe loads `mute_wdata` into `mute_state` only when `buf_full` is 0; while `buf_full` is 1 the write has no effect.
- R8: A `data_rd` strobe with no store in the same cycle clears `buf_full` and `overrun` at the next edge.
- R9: A character that would be stored while `buf_full` is 1 and no read is strobed sets `overrun`, leaves `rd_data` unchanged, and raises no `rx_req`.
- R10: `rx_req` is high for exactly the cycle after each store and never while `buf_full` is 0.
- R11: The stored value keeps all 9 word bits when `len_nine`=1; with `len_nine`=0, bit 8 of `rd_data` reads 0.
- R12: In one cycle, an address character overrides a `mute_wr` strobe. A `data_rd` together with an accepted character stores the new character, keeps `buf_full` at 1 and pulses `rx_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_valid | input | 1 | One-cycle strobe: a character word is complete |
| char_word | input | 9 | Received character word, parity included |
| len_nine | input | 1 | Frame length select: 1 = 9-bit word, 0 = 8-bit word |
| par_en | input | 1 | Parity enable: the top word bit is parity |
| node_addr | input | 4 | This node's address |
| mute_wr | input | 1 | Software write strobe for the mute state |
| mute_wdata | input | 1 | Value written to the mute state |
| data_rd | input | 1 | Software read strobe of the stored character |
| rd_data | output | 9 | Stored character |
| buf_full | output | 1 | Holding register contains an unread character |
| rx_req | output | 1 | One-cycle interrupt/DMA request per stored character |
| overrun | output | 1 | A character arrived while the register was full |
| mute_state | output | 1 | Current mute state (1 = muted) |
| msb_idx | output | 4 | Bit position of the data MSB, for the parity checker |

## Verification
Two pairs of events can land in the same cycle. A software mute write can meet an arriving address character, and a read of the holding register can meet a newly accepted character. The bench drives each pair on one edge. For the first pair it checks that the address decision sets `mute_state` and that the written value is lost. For the second it checks that `buf_full` stays high, `rd_data` takes the new character, `rx_req` pulses and `overrun` stays clear.

// File: rtl/rxmf_pkg.sv
package rxmf_pkg;
  typedef struct packed {
    logic is_addr;
    logic match;
  } rxmf_class_t;
endpackage

// File: rtl/rxmf_format.sv
module rxmf_format #(
  parameter int WORD_W = 9,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              len_nine,
  input  logic              par_en,
  output logic [IDX_W-1:0]  idx_now,
  output logic [WORD_W-1:0] keep_mask,
  output logic [IDX_W-1:0]  idx_q
);
  always_comb begin
    case ({len_nine, par_en})
      2'b10:   idx_now = IDX_W'(WORD_W - 1);
      2'b11:   idx_now = IDX_W'(WORD_W - 2);
      2'b00:   idx_now = IDX_W'(WORD_W - 2);
      default: idx_now = IDX_W'(WORD_W - 3);
    endcase
    keep_mask = len_nine ? {WORD_W{1'b1}} : {1'b0, {(WORD_W-1){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx_now;
  end
endmodule

// File: rtl/rxmf_classify.sv
module rxmf_classify
  import rxmf_pkg::*;
#(
  parameter int WORD_W = 9,
  parameter int ADDR_W = 4,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] node_addr,
  output rxmf_class_t       cls
);
  logic [WORD_W-1:0] shifted;
  always_comb begin
    shifted     = word >> idx;
    cls.is_addr = shifted[0];
    cls.match   = (word[ADDR_W-1:0] == node_addr);
  end
endmodule

// File: rtl/rxmf_mute_ctl.sv
module rxmf_mute_ctl
  import rxmf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        char_valid,
  input  rxmf_class_t cls,
  input  logic        mute_wr,
  input  logic        mute_wdata,
  input  logic        buf_full,
  output logic        accept,
  output logic        mute_q
);
  always_comb begin
    if (!char_valid)     accept = 1'b0;
    else if (cls.is_addr) accept = cls.match;
    else                 accept = !mute_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      mute_q <= 1'b0;
    else if (char_valid && cls.is_addr)
      mute_q <= !cls.match;
    else if (mute_wr && !buf_full)
      mute_q <= mute_wdata;
  end
endmodule

// File: rtl/rxmf_holding.sv
module rxmf_holding #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] keep_mask,
  input  logic              data_rd,
  output logic [WORD_W-1:0] data_q,
  output logic              full_q,
  output logic              req_q,
  output logic              ovr_q
);
  logic store;
  logic lost;
  always_comb begin
    store = accept && (!full_q || data_rd);
    lost  = accept && full_q && !data_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
      req_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      req_q <= store;
      if (store)        data_q <= word & keep_mask;
      if (store)        full_q <= 1'b1;
      else if (data_rd) full_q <= 1'b0;
      if (lost)         ovr_q  <= 1'b1;
      else if (data_rd) ovr_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_mute_filter.sv
module rx_mute_filter
  import rxmf_pkg::*;
#(
  parameter int WORD_W = 9,
  parameter int ADDR_W = 4,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_valid,
  input  logic [WORD_W-1:0] char_word,
  input  logic              len_nine,
  input  logic              par_en,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              mute_wr,
  input  logic              mute_wdata,
  input  logic              data_rd,
  output logic [WORD_W-1:0] rd_data,
  output logic              buf_full,
  output logic              rx_req,
  output logic              overrun,
  output logic              mute_state,
  output logic [IDX_W-1:0]  msb_idx
);
  logic [IDX_W-1:0]  idx_now;
  logic [WORD_W-1:0] keep_mask;
  rxmf_class_t       cls;
  logic              accept;

  rxmf_format #(.WORD_W(WORD_W)) u_format (
    .clk(clk), .rst(rst), .len_nine(len_nine), .par_en(par_en),
    .idx_now(idx_now), .keep_mask(keep_mask), .idx_q(msb_idx)
  );

  rxmf_classify #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_classify (
    .word(char_word), .idx(idx_now), .node_addr(node_addr), .cls(cls)
  );

  rxmf_mute_ctl u_mute (
    .clk(clk), .rst(rst), .char_valid(char_valid), .cls(cls),
    .mute_wr(mute_wr), .mute_wdata(mute_wdata), .buf_full(buf_full),
    .accept(accept), .mute_q(mute_state)
  );

  rxmf_holding #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst(rst), .accept(accept), .word(char_word),
    .keep_mask(keep_mask), .data_rd(data_rd), .data_q(rd_data),
    .full_q(buf_full), .req_q(rx_req), .ovr_q(overrun)
  );
endmodule

// File: rtl/rx_mute_filter_chk.sv
module rx_mute_filter_chk #(
  parameter int WORD_W = 9,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              char_valid,
  input logic [WORD_W-1:0] char_word,
  input logic              len_nine,
  input logic              par_en,
  input logic [ADDR_W-1:0] node_addr,
  input logic              mute_wr,
  input logic              data_rd,
  input logic [WORD_W-1:0] rd_data,
  input logic              buf_full,
  input logic              rx_req,
  input logic              overrun,
  input logic              mute_state
);
  logic mark;
  logic hit;
  always_comb begin
    case ({len_nine, par_en})
      2'b10:   mark = char_word[WORD_W-1];
      2'b11:   mark = char_word[WORD_W-2];
      2'b00:   mark = char_word[WORD_W-2];
      default: mark = char_word[WORD_W-3];
    endcase
    hit = (char_word[ADDR_W-1:0] == node_addr);
  end

  // R4
  mismatch_mutes_chk: assert property (@(posedge clk) disable iff (rst)
    char_valid && mark && !hit |=> mute_state && !rx_req);

  // R5
  match_accepts_chk: assert property (@(posedge clk) disable iff (rst)
    char_valid && mark && hit |=> !mute_state && buf_full);

  // R7
  locked_write_chk: assert property (@(posedge clk) disable iff (rst)
    mute_wr && buf_full && !char_valid |=> $stable(mute_state));

  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    data_rd && !char_valid |=> !buf_full && !overrun);

  // R9
  held_data_chk: assert property (@(posedge clk) disable iff (rst)
    buf_full && !data_rd |=> $stable(rd_data));

  // R10
  req_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    rx_req |-> buf_full);
endmodule

bind rx_mute_filter rx_mute_filter_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .char_valid(char_valid), .char_word(char_word),
  .len_nine(len_nine), .par_en(par_en), .node_addr(node_addr),
  .mute_wr(mute_wr), .data_rd(data_rd), .rd_data(rd_data),
  .buf_full(buf_full), .rx_req(rx_req), .overrun(overrun),
  .mute_state(mute_state)
);

// File: tb/rx_mute_filter_tb.sv
module rx_mute_filter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       char_valid = 1'b0;
  logic [8:0] char_word = '0;
  logic       len_nine = 1'b0;
  logic       par_en = 1'b0;
  logic [3:0] node_addr = 4'h1;
  logic       mute_wr = 1'b0;
  logic       mute_wdata = 1'b0;
  logic       data_rd = 1'b0;
  logic [8:0] rd_data;
  logic       buf_full, rx_req, overrun, mute_state;
  logic [3:0] msb_idx;

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_mute_filter u_dut (
    .clk(clk), .rst(rst), .char_valid(char_valid), .char_word(char_word),
    .len_nine(len_nine), .par_en(par_en), .node_addr(node_addr),
    .mute_wr(mute_wr), .mute_wdata(mute_wdata), .data_rd(data_rd),
    .rd_data(rd_data), .buf_full(buf_full), .rx_req(rx_req),
    .overrun(overrun), .mute_state(mute_state), .msb_idx(msb_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // One clock: inputs applied after a falling edge, outputs read at the next one.
  task automatic cyc(input logic v, input logic [8:0] w, input logic mw,
                     input logic md, input logic rd);
    char_valid = v; char_word = w; mute_wr = mw; mute_wdata = md; data_rd = rd;
    @(negedge clk);
    char_valid = 1'b0; mute_wr = 1'b0; data_rd = 1'b0;
  endtask

  task automatic fmt(input logic m, input logic p);
    len_nine = m; par_en = p;
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic t_reset;
    chk("R1 buf_full", buf_full, 0);
    chk("R1 rx_req", rx_req, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 mute_state", mute_state, 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_msb_index;
    fmt(1, 0); chk("R2 9-bit", msb_idx, 8);
    fmt(1, 1); chk("R2 8+parity", msb_idx, 7);
    fmt(0, 1); chk("R2 7+parity", msb_idx, 6);
    fmt(0, 0); chk("R2 8-bit", msb_idx, 7);
  endtask

  task automatic t_address_flow;
    fmt(0, 0);
    cyc(1, 9'h082, 0, 0, 0);
    chk("R4 mute set", mute_state, 1);
    chk("R4 no store", buf_full, 0);
    chk("R4 no req", rx_req, 0);
    cyc(1, 9'h012, 0, 0, 0);
    chk("R6 muted drop", buf_full, 0);
    cyc(1, 9'h083, 0, 0, 0);
    chk("R4 stays muted", mute_state, 1);
    cyc(1, 9'h081, 0, 0, 0);
    chk("R5 unmute", mute_state, 0);
    chk("R5 full", buf_full, 1);
    chk("R5 data", rd_data, 9'h081);
    chk("R10 req pulse", rx_req, 1);
    cyc(0, 0, 0, 0, 0);
    chk("R10 req one cycle", rx_req, 0);
    cyc(1, 9'h033, 0, 0, 0);
    chk("R9 overrun", overrun, 1);
    chk("R9 data kept", rd_data, 9'h081);
    chk("R9 no req", rx_req, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R8 full cleared", buf_full, 0);
    chk("R8 overrun cleared", overrun, 0);
    cyc(1, 9'h044, 0, 0, 0);
    chk("R6 normal store", rd_data, 9'h044);
    cyc(0, 0, 1, 1, 0);
    chk("R7 write ignored while full", mute_state, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 1, 1, 0);
    chk("R7 write taken while empty", mute_state, 1);
    cyc(0, 0, 1, 0, 0);
    chk("R7 write clears", mute_state, 0);
  endtask

  task automatic t_parity_mark;
    fmt(0, 1);
    cyc(0, 0, 1, 1, 0);
    cyc(1, 9'h081, 0, 0, 0);
    chk("R3 parity bit not a mark", buf_full, 0);
    chk("R3 still muted", mute_state, 1);
    cyc(1, 9'h041, 0, 0, 0);
    chk("R3 bit6 mark", mute_state, 0);
    chk("R3 bit6 stored", rd_data, 9'h041);
    cyc(0, 0, 0, 0, 1);
    fmt(1, 1);
    cyc(1, 9'h100, 0, 0, 0);
    chk("R3 bit8 parity is data", rd_data, 9'h100);
    chk("R3 not muted", mute_state, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(1, 9'h182, 0, 0, 0);
    chk("R3 bit7 mark mismatch", mute_state, 1);
    fmt(1, 0);
    cyc(1, 9'h0F1, 0, 0, 0);
    chk("R3 9-bit bit7 is data", buf_full, 0);
    cyc(1, 9'h101, 0, 0, 0);
    chk("R11 9-bit kept", rd_data, 9'h101);
    cyc(0, 0, 0, 0, 1);
    fmt(0, 0);
    cyc(1, 9'h123, 0, 0, 0);
    chk("R11 bit8 masked", rd_data, 9'h023);
    cyc(0, 0, 0, 0, 1);
  endtask

  task automatic t_collisions;
    fmt(0, 0);
    cyc(1, 9'h085, 1, 0, 0);
    chk("R12 address beats write", mute_state, 1);
    cyc(1, 9'h081, 1, 1, 0);
    chk("R12 match beats write", mute_state, 0);
    chk("R12 match stored", buf_full, 1);
    cyc(0, 0, 0, 0, 0);
    cyc(1, 9'h055, 0, 0, 1);
    chk("R12 read+store full", buf_full, 1);
    chk("R12 read+store data", rd_data, 9'h055);
    chk("R12 read+store req", rx_req, 1);
    chk("R12 read+store no overrun", overrun, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R10 no req when empty", rx_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_msb_index();
    t_address_flow();
    t_parity_mark();
    t_collisions();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        applied++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule